// File: doc/BRIEF.md
# Multi-Master Shared-Bus Arbiter

This block decides which of several bus masters owns a pipelined shared bus, where each transfer has a one-cycle address phase followed by a data phase that the addressed slave may stretch. Each master raises a request line and, optionally, a lock line. The arbiter answers with a one-hot grant vector, an index naming the master whose transfer is now in its data phase, and a flag that marks that transfer as part of a locked sequence. Grants move only on edges where the bus reports ready, so an address phase is never cut short.

The lowest-numbered master that is eligible wins. A master holding its lock keeps the bus against higher-priority requests. A slave that cannot finish a transfer may answer with a split response. The arbiter then parks the master that owned that data phase and leaves it out of arbitration until the slave raises the matching bit of a release vector. When no eligible master requests, a parameter-selected default master holds the grant. All pins are plain control and status; no stream interface is involved.

Top module: `bus_arbiter`

## Requirements
- R1: During and right after reset, `grant` is one-hot on the default master (parameter `DFLT_MASTER`, default 15), `owner_id` equals `DFLT_MASTER`, `owner_locked` is 0 and no master is parked.
- R2: `grant` has exactly one bit set in every cycle.
- R3: On an edge where `xfer_ready` is 0, `grant`, `owner_id` and `owner_locked` keep their values.
- R4: On an edge where `xfer_ready` is 1 and no lock holds, the grant goes to the lowest-numbered master whose `bus_req` bit is 1 and that is not parked.
- R5: On such an edge, if no unparked master requests, the grant goes to `DFLT_MASTER`.
- R6: On an edge where `xfer_ready` is 1, if the currently granted master has its `bus_lock` bit at 1 and is not parked, it keeps the grant whatever the other requests are.
- R7: On an edge where `xfer_ready` is 1, `owner_id` takes the index of the master granted before that edge, and `owner_locked` takes that master's `bus_lock` bit.
- R8: On an edge where `xfer_ready` is 1 and `xfer_resp` equals 2'b11 (split), the master named by `owner_id` becomes parked and is skipped by arbitration, from that same edge's decision onward.
- R9: A 1 on bit i of `split_release` at any edge un-parks master i, and that edge's decision already sees it eligible; if a park and a release for the same master meet on one edge, the release wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_req | input | NUM_MASTERS | Per-master bus request |
| bus_lock | input | NUM_MASTERS | Per-master locked-sequence request |
| xfer_ready | input | 1 | Current transfer completes this cycle |
| xfer_resp | input | 2 | Slave response; 2'b11 means split |
| split_release | input | NUM_MASTERS | Per-master release of a parked master |
| grant | output | NUM_MASTERS | One-hot grant |
| owner_id | output | ID_W | Master owning the current data phase |
| owner_locked | output | 1 | Current data-phase transfer belongs to a locked sequence |

## Verification
The assertions assume that `xfer_resp` carries split only on a cycle whose owner is a real transfer, and that a lock line is raised only by a master that also requests; they do not depend on the release vector being one-hot. Stimulus is driven at the falling edge, with directed sequences for priority, default grant, locks, stalls, parking and release, then a long pseudo-random stretch with sparse split responses, single-bit releases, rare locks and ready low about a quarter of the time. A behavioural model built on integers predicts every output after each edge.

// File: rtl/arb_pkg.sv
package arb_pkg;
  localparam logic [1:0] RESP_SPLIT = 2'b11;
endpackage

// File: rtl/arb_prio.sv
module arb_prio #(
  parameter int N = 16
) (
  input  logic [N-1:0] cand,
  output logic [N-1:0] pick_oh,
  output logic         any
);
  logic [N:0] seen;
  assign seen[0] = 1'b0;

  genvar i;
  generate
    for (i = 0; i < N; i++) begin : g_chain
      assign seen[i+1]  = seen[i] | cand[i];
      assign pick_oh[i] = cand[i] & ~seen[i];
    end
  endgenerate

  assign any = seen[N];

  always_comb begin
    assert_pick_lowest_R4: assert (((pick_oh - 1'b1) & cand & {N{any}}) == '0);
  end
endmodule

// File: rtl/arb_enc.sv
module arb_enc #(
  parameter int N  = 16,
  parameter int IW = 4
) (
  input  logic [N-1:0]  oh,
  output logic [IW-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = 0; i < N; i++) begin
      if (oh[i]) idx = idx | IW'(i);
    end
  end
endmodule

// File: rtl/arb_split_mask.sv
module arb_split_mask #(
  parameter int N  = 16,
  parameter int IW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          park_en,
  input  logic [IW-1:0] park_idx,
  input  logic [N-1:0]  release_v,
  output logic [N-1:0]  mask_nxt,
  output logic [N-1:0]  mask_q
);
  genvar i;
  generate
    for (i = 0; i < N; i++) begin : g_bit
      assign mask_nxt[i] = (mask_q[i] | (park_en && park_idx == IW'(i))) & ~release_v[i];
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mask_q[i] <= 1'b0;
        else        mask_q[i] <= mask_nxt[i];
      end
    end
  endgenerate

  assert_release_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (|release_v) |=> ((mask_q & $past(release_v)) == '0));

  assert_park_sets_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (park_en && !release_v[park_idx]) |=> mask_q[$past(park_idx)]);
endmodule

// File: rtl/bus_arbiter.sv
module bus_arbiter #(
  parameter int NUM_MASTERS = 16,
  parameter int DFLT_MASTER = 15,
  localparam int ID_W = (NUM_MASTERS > 1) ? $clog2(NUM_MASTERS) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NUM_MASTERS-1:0] bus_req,
  input  logic [NUM_MASTERS-1:0] bus_lock,
  input  logic                   xfer_ready,
  input  logic [1:0]             xfer_resp,
  input  logic [NUM_MASTERS-1:0] split_release,
  output logic [NUM_MASTERS-1:0] grant,
  output logic [ID_W-1:0]        owner_id,
  output logic                   owner_locked
);
  import arb_pkg::*;

  localparam logic [NUM_MASTERS-1:0] DFLT_OH = NUM_MASTERS'(1) << DFLT_MASTER;

  logic [NUM_MASTERS-1:0] grant_q, grant_nxt, mask_nxt, mask_q, pick_oh;
  logic [ID_W-1:0]        cur_idx, owner_q;
  logic                   locked_q, pick_any, hold_lock, park_en;

  arb_enc #(.N(NUM_MASTERS), .IW(ID_W)) u_enc (
    .oh  (grant_q),
    .idx (cur_idx)
  );

  assign park_en = xfer_ready && (xfer_resp == RESP_SPLIT);

  arb_split_mask #(.N(NUM_MASTERS), .IW(ID_W)) u_mask (
    .clk       (clk),
    .rst_n     (rst_n),
    .park_en   (park_en),
    .park_idx  (owner_q),
    .release_v (split_release),
    .mask_nxt  (mask_nxt),
    .mask_q    (mask_q)
  );

  arb_prio #(.N(NUM_MASTERS)) u_prio (
    .cand    (bus_req & ~mask_nxt),
    .pick_oh (pick_oh),
    .any     (pick_any)
  );

  assign hold_lock = bus_lock[cur_idx] & ~mask_nxt[cur_idx];

  always_comb begin
    if (hold_lock)     grant_nxt = grant_q;
    else if (pick_any) grant_nxt = pick_oh;
    else               grant_nxt = DFLT_OH;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grant_q  <= DFLT_OH;
      owner_q  <= ID_W'(DFLT_MASTER);
      locked_q <= 1'b0;
    end else if (xfer_ready) begin
      grant_q  <= grant_nxt;
      owner_q  <= cur_idx;
      locked_q <= bus_lock[cur_idx];
    end
  end

  assign grant        = grant_q;
  assign owner_id     = owner_q;
  assign owner_locked = locked_q;

  assert_grant_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(grant) == 1);

  assert_stall_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer_ready |=> ($stable(grant) && $stable(owner_id) && $stable(owner_locked)));

  assert_lock_keeps_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_ready && |(grant & bus_lock & ~mask_nxt)) |=> (grant == $past(grant)));

  assert_owner_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_ready |=> (owner_id == $past(cur_idx)));

  assert_parked_not_granted_R8: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_ready |=> ((grant & mask_q) == '0 || grant == DFLT_OH));
endmodule

// File: tb/bus_arbiter_tb_top.sv
module bus_arbiter_tb_top;
  localparam int N = 16;
  localparam int DF = 15;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] req = '0, lck = '0, rel = '0;
  logic rdy = 1'b0;
  logic [1:0] rsp = 2'b00;
  logic [N-1:0] grant;
  logic [3:0] owner_id;
  logic owner_locked;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  int m_g, m_own, m_lk;
  bit [N-1:0] m_mask;

  always #4 clk = ~clk;

  bus_arbiter #(.NUM_MASTERS(N), .DFLT_MASTER(DF)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_req(req), .bus_lock(lck),
    .xfer_ready(rdy), .xfer_resp(rsp), .split_release(rel),
    .grant(grant), .owner_id(owner_id), .owner_locked(owner_locked)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic compare_all(input string tag);
    int ones = 0;
    int idx = -1;
    for (int i = 0; i < N; i++) if (grant[i]) begin ones++; idx = i; end
    chk("R2 grant onehot", ones, 1);
    chk({tag, " grant"}, idx, m_g);
    chk("R7 owner_id", int'(owner_id), m_own);
    chk("R7 owner_locked", int'(owner_locked), m_lk);
  endtask

  task automatic step(input logic [N-1:0] r, input logic [N-1:0] l, input logic y,
                      input logic [1:0] s, input logic [N-1:0] e, input string tag);
    bit [N-1:0] mn;
    int gn, on, ln;
    @(negedge clk);
    req = r; lck = l; rdy = y; rsp = s; rel = e;
    mn = m_mask;
    if (y && s == 2'b11) mn[m_own] = 1'b1;
    mn = mn & ~e;
    gn = m_g; on = m_own; ln = m_lk;
    if (y) begin
      if (l[m_g] && !mn[m_g]) gn = m_g;
      else begin
        gn = DF;
        for (int i = N - 1; i >= 0; i--) if (r[i] && !mn[i]) gn = i;
      end
      on = m_g;
      ln = int'(l[m_g]);
    end
    @(posedge clk);
    #1;
    m_mask = mn; m_g = gn; m_own = on; m_lk = ln;
    compare_all(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    m_g = DF; m_own = DF; m_lk = 0; m_mask = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    compare_all("R1");
    rst_n = 1'b1;
    // R1: parked set empty -> an idle ready edge keeps default
    step('0, '0, 1'b1, 2'b00, '0, "R1");
    // R4: lowest index wins
    step(16'h1010, '0, 1'b1, 2'b00, '0, "R4");
    step(16'h0a00, '0, 1'b1, 2'b00, '0, "R4");
    // R5: nobody requests -> default
    step('0, '0, 1'b1, 2'b00, '0, "R5");
    // R6: lock held by master 5 against master 0
    step(16'h0020, 16'h0020, 1'b1, 2'b00, '0, "R6");
    step(16'h0021, 16'h0020, 1'b1, 2'b00, '0, "R6");
    step(16'h0021, 16'h0020, 1'b1, 2'b00, '0, "R6");
    step(16'h0021, 16'h0000, 1'b1, 2'b00, '0, "R6");
    // R3: stall keeps everything
    step(16'h0040, '0, 1'b1, 2'b00, '0, "R3");
    step(16'h0001, '0, 1'b0, 2'b00, '0, "R3");
    step(16'h0001, 16'h0001, 1'b0, 2'b00, '0, "R3");
    step(16'h0040, '0, 1'b1, 2'b00, '0, "R3");
    // R8: park master 2 while it owns the data phase
    step(16'h0004, '0, 1'b1, 2'b00, '0, "R8");
    step(16'h0004, '0, 1'b1, 2'b00, '0, "R8");
    step(16'h000c, '0, 1'b1, 2'b11, '0, "R8");
    step(16'h000c, '0, 1'b1, 2'b00, '0, "R8");
    step(16'h0004, '0, 1'b1, 2'b00, '0, "R8");
    // R9: release makes master 2 eligible on the same edge
    step(16'h000c, '0, 1'b1, 2'b00, 16'h0004, "R9");
    step(16'h0004, '0, 1'b1, 2'b00, '0, "R9");
    // R9: park and release for the same master collide -> release wins
    step(16'h0004, '0, 1'b1, 2'b11, 16'h0004, "R9");
    step(16'h0004, '0, 1'b1, 2'b00, '0, "R9");
    // mixed pseudo-random traffic
    for (int k = 0; k < 3000; k++) begin
      logic [N-1:0] r, l, e;
      logic y;
      logic [1:0] s;
      r = N'($urandom) & N'($urandom);
      l = (($urandom % 8) == 0) ? (r & N'($urandom)) : '0;
      y = ($urandom % 4) != 0;
      s = (($urandom % 16) == 0) ? 2'b11 : 2'b00;
      e = (($urandom % 8) == 0) ? (N'(1) << ($urandom % N)) : '0;
      step(r, l, y, s, e, "R4");
    end
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule